// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the series of column addresses that a DRAM-style burst touches. A request carries a starting column, a length of four or eight beats, and a bit that picks between two orderings: wrapped counting or XOR-interleaved. When a request is accepted, the block stores it. Starting in the next cycle it gives one column address per cycle. Each address comes with a valid flag, and the final beat is also marked.

Only the lowest two or three column bits are reordered within the burst window. The remaining upper bits are copied from the request unchanged. For length four, bit 2 of the start is also copied unchanged. While a burst is running the block reports busy and ignores further requests. A new request can be taken in the first cycle after the final beat.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset clears `valid_o`, `last_o` and `busy_o` by the next clock edge, including in the middle of a burst.
- R2: A request (`start_i` high while `busy_o` is low) is accepted at a clock edge. Beat 0 is presented in the cycle after that edge. `valid_o` then stays high for exactly 4 consecutive cycles when `bl8_i`=0, or 8 when `bl8_i`=1, and is low in the cycle after the final beat.
- R3: `last_o` is high only in the cycle of the final beat, and only together with `valid_o`.
- R4: `start_i` is ignored while `busy_o` is high. The running burst continues with its original address, length and mode.
- R5: With length 4 and sequential mode (`interleave_i`=0), output bits [1:0] of beat i equal (s+i) mod 4, where s is start bits [1:0]. Output bit 2 equals start bit 2.
- R6: With length 4 and interleaved mode (`interleave_i`=1), output bits [1:0] of beat i equal s XOR i, and output bit 2 equals start bit 2.
- R7: With length 8 and sequential mode, output bits [1:0] of beat i equal (start[1:0]+i) mod 4, and output bit 2 equals start bit 2 XOR bit 2 of i. For example, start 6 gives 6,7,4,5,2,3,0,1.
- R8: With length 8 and interleaved mode, output bits [2:0] of beat i equal start[2:0] XOR i.
- R9: Output bits [COL_W-1:3] equal the same bits of the accepted start column on every beat.
- R10: Length and mode are sampled only when a request is accepted. Changes to `bl8_i` or `interleave_i` during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | 1 = eight beats, 0 = four beats |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | Burst running; requests are refused |

## Verification
The bench runs every start offset under both lengths and both orderings, with the upper column bits varied. This exposes an eight-beat sequential walk that wraps linearly (start 6 would give 6,7,0,1 instead of 6,7,4,5), and a length-four burst that changes bit 2. During some bursts the bench asserts a stray request and flips the length and mode inputs. A design that takes those inputs mid-burst then shows a restarted or reordered series. A burst is cut by reset to catch flags that survive reset, and the check on the cycle after each final beat catches an off-by-one burst length.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

  localparam int unsigned OFF_W = 3;

  typedef logic [OFF_W-1:0] off_t;

  typedef struct packed {
    logic bl8;
    logic ilv;
  } burst_cfg_t;

  // Wrapped order: the low pair counts modulo four. Bit 2 flips once the
  // first half has been walked, and only for eight-beat bursts.
  function automatic off_t seq_offset(input off_t s, input off_t b, input logic bl8);
    off_t r;
    r[1:0] = s[1:0] + b[1:0];
    r[2]   = s[2] ^ (bl8 & b[2]);
    return r;
  endfunction

  // Interleaved order: start XOR beat. Bit 2 of the beat is masked for four beats.
  function automatic off_t ilv_offset(input off_t s, input off_t b, input logic bl8);
    off_t m;
    m = {bl8 & b[2], b[1:0]};
    return s ^ m;
  endfunction

  function automatic off_t final_beat(input logic bl8);
    return bl8 ? off_t'(7) : off_t'(3);
  endfunction

endpackage

// File: rtl/burst_req_latch.sv
module burst_req_latch
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [COL_W-1:0] col_in,
  input  burst_cfg_t       cfg_in,
  output logic [COL_W-1:0] col_held,
  output burst_cfg_t       cfg_held
);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_held <= '0;
      cfg_held <= '0;
    end else if (accept) begin
      col_held <= col_in;
      cfg_held <= cfg_in;
    end
  end

  AST_HOLD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(col_held) && $stable(cfg_held))); // R10

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic bl8,
  output off_t beat,
  output logic active,
  output logic final_now
);

  assign final_now = active && (beat == final_beat(bl8));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (final_now) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + off_t'(1);
      end
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && !final_now) |=> (active && beat == $past(beat) + off_t'(1))); // R2
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (beat <= final_beat(bl8))); // R2

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] col_base,
  input  burst_cfg_t       cfg,
  input  off_t             beat,
  output logic [COL_W-1:0] col_out
);

  localparam int unsigned UP_W = COL_W - OFF_W;

  off_t s_off;
  off_t seq_v;
  off_t ilv_v;

  assign s_off = col_base[OFF_W-1:0];
  assign seq_v = seq_offset(s_off, beat, cfg.bl8);
  assign ilv_v = ilv_offset(s_off, beat, cfg.bl8);

  generate
    if (UP_W > 0) begin : g_upper
      assign col_out = {col_base[COL_W-1:OFF_W], cfg.ilv ? ilv_v : seq_v};
    end else begin : g_flat
      assign col_out = cfg.ilv ? ilv_v : seq_v;
    end
  endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);

  logic             start_accept;
  logic             run_active;
  logic             run_final;
  off_t             run_beat;
  logic [COL_W-1:0] held_col;
  burst_cfg_t       held_cfg;
  burst_cfg_t       req_cfg;

  assign req_cfg      = '{bl8: bl8_i, ilv: interleave_i};
  assign start_accept = start_i && !run_active;

  burst_req_latch #(.COL_W(COL_W)) u_latch (
    .clk(clk), .rst(rst), .accept(start_accept),
    .col_in(start_col_i), .cfg_in(req_cfg),
    .col_held(held_col), .cfg_held(held_cfg)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .accept(start_accept), .bl8(held_cfg.bl8),
    .beat(run_beat), .active(run_active), .final_now(run_final)
  );

  burst_offset_map #(.COL_W(COL_W)) u_map (
    .col_base(held_col), .cfg(held_cfg), .beat(run_beat), .col_out(col_o)
  );

  assign valid_o = run_active;
  assign busy_o  = run_active;
  assign last_o  = run_final;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!valid_o && !busy_o && !last_o)); // R1
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !valid_o); // R2
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R3
  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !last_o) |=> (valid_o && $stable(held_col))); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !held_cfg.ilv) |=>
      (col_o[1:0] == $past(col_o[1:0]) + 2'd1)); // R5
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> (col_o[COL_W-1:OFF_W] == $past(col_o[COL_W-1:OFF_W]))); // R9

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic             bl8_i;
  logic             interleave_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .interleave_i(interleave_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected column for beat i, worked out arithmetically from the requirements.
  function automatic int expect_col(int base, int bl8, int ilv, int i);
    int s = base % 8;
    int up = base - s;
    int off;
    if (ilv != 0) begin
      if (bl8 != 0) off = s ^ i;                 // R8
      else off = (s & 4) + ((s % 4) ^ i);        // R6
    end else begin
      int lo = (s + i) % 4;
      int hi = (s / 4) % 2;
      if (bl8 != 0 && i >= 4) hi = 1 - hi;       // R7
      off = hi * 4 + lo;                         // R5
    end
    return up + off;
  endfunction

  task automatic run_burst(input int base, input int bl8, input int ilv, input bit disturb);
    int n = (bl8 != 0) ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; start_col_i = base[COL_W-1:0];
    bl8_i = bl8[0]; interleave_i = ilv[0];
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      bl8_i = ~bl8_i; interleave_i = ~interleave_i;  // R10
    end
    for (int i = 0; i < n; i++) begin
      int exp_c = expect_col(base, bl8, ilv, i);
      check(valid_o && busy_o, "R2 valid", int'(valid_o), 1);
      check(col_o == exp_c[COL_W-1:0], ilv != 0 ? (bl8 != 0 ? "R8 order" : "R6 order")
            : (bl8 != 0 ? "R7 order" : "R5 order"), int'(col_o), exp_c);
      check((col_o >> 3) == (base >> 3), "R9 upper", int'(col_o >> 3), base >> 3);
      check(last_o == (i == n - 1), "R3 last", int'(last_o), int'(i == n - 1));
      if (disturb && i == 1) begin
        start_i = 1'b1;                            // R4 stray request
        start_col_i = ~base[COL_W-1:0];
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(!valid_o && !busy_o && !last_o, "R2 end", int'(valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; bl8_i = 1'b0; interleave_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!valid_o && !busy_o && !last_o, "R1 reset", int'(valid_o), 0);

    for (int k = 0; k < 3; k++)
      for (int bl = 0; bl < 2; bl++)
        for (int il = 0; il < 2; il++)
          for (int s = 0; s < 8; s++)
            run_burst(((s * 37 + k * 211 + bl * 64) % 128) * 8 + s, bl, il, (s + k) % 2 == 1);

    // R1: reset in the middle of a burst
    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'd5; bl8_i = 1'b1; interleave_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!valid_o && !busy_o && !last_o, "R1 mid-burst reset", int'(valid_o), 0);
    rst = 1'b0;
    run_burst(3, 0, 1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule